// File: doc/BRIEF.md
# Byte-Lane Interleaving Aggregator

This block merges up to eight slow byte lanes into one fast byte stream. Time on the output is divided into frames of eight slots. Slot k always belongs to lane k, whether or not that lane is connected. The output produces one byte per clock and raises a marker on the first slot of every frame. A lane can be plugged in or pulled out while the block runs. When a lane is absent, or has no fresh byte, its slot carries a programmable filler byte, so the slots of the other lanes never shift.

Each lane feeds a one-byte holding register. The register loads when the lane is present and its valid flag is high. It empties once its slot has gone out. A lane that runs at a whole-number fraction of the fastest lane's rate therefore fills its slot only in the frames where it delivered a byte, and sends filler in the other frames.

A single-lane pass-through mode forwards lane 0 at the same rate, without framing. The mode request is taken only at the end of a frame.

Top module: `byte_lane_aggregator`

## Requirements
- R1: While reset is high, `agg_byte_o` is 0x00 and `frame_start_o` is 0. The eight bytes produced on the eight edges after reset are all filler, whatever the lane inputs are. The first of these bytes carries `frame_start_o` = 1.
- R2: In interleave mode, `frame_start_o` is 1 on exactly one output cycle in every eight, and that cycle is slot 0.
- R3: In interleave mode, output slot k (counting from 0 after `frame_start_o`) carries the byte held for lane k, where lane k is bits [8k+7:8k] of `lane_data_i`. Lane k is then released in its next slot after capture.
- R4: A lane whose `lane_present_i` bit is 0 gets the filler byte in its slot, and its input bytes are never captured.
- R5: A present lane whose register received no byte since its slot was last sent gets filler, because the register empties when its slot goes out.
- R6: Changing `lane_present_i` at any cycle does not move or change the slots of any other lane.
- R7: A lane that delivers one byte every d frames (d = 1..4) shows its byte in one frame out of d, and filler in the others.
- R8: The filler value resets to 0x00. A cycle with `filler_we_i` = 1 loads `filler_wdata_i`, and the new value is used from the next output byte on.
- R9: In pass-through mode (`mode_sel_i` = 1), each output byte is lane 0's byte from the previous cycle if lane 0 was valid and present, and filler otherwise. `frame_start_o` stays 0.
- R10: `mode_sel_i` is sampled only on the last slot of a frame, so the new mode starts at a frame boundary.
- R11: If a lane is valid on several cycles before its slot, the most recent byte is the one sent.
- R12: A byte captured on the very cycle its lane's slot is being sent goes out in the following frame, not the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, one output slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| lane_data_i | input | 64 | Lane bytes, lane k in bits [8k+7:8k] |
| lane_valid_i | input | 8 | Per-lane byte-valid strobe |
| lane_present_i | input | 8 | Per-lane connected flag |
| mode_sel_i | input | 1 | Mode request: 0 interleave, 1 single-lane pass-through |
| filler_we_i | input | 1 | Load strobe for the filler value |
| filler_wdata_i | input | 8 | New filler value |
| agg_byte_o | output | 8 | Aggregated output byte |
| frame_start_o | output | 1 | High on slot 0 of each interleave frame |

## Verification
A slot counter that is off by one would show up within a single frame. Every lane's byte would land one slot over, and the marker would drift away from the first filler byte after reset. A holding register that fails to empty would replay stale data on the next frame where that lane is idle, so the fractional-rate and sparse-valid runs expose it within one to four frames. A mode register that updates mid-frame would put a pass-through byte or a lost marker inside a frame, within eight cycles of the request.

// File: rtl/lane_agg_pkg.sv
package lane_agg_pkg;

    localparam int unsigned SLOTS_PER_FRAME = 8;
    localparam int unsigned LANE_BYTE_W     = 8;

    typedef enum logic {
        AGG_INTERLEAVE = 1'b0,
        AGG_PASS       = 1'b1
    } agg_mode_e;

    typedef struct packed {
        logic                   full;
        logic [LANE_BYTE_W-1:0] data;
    } lane_hold_t;

    function automatic logic hold_ready(input lane_hold_t h, input logic present);
        return h.full && present;
    endfunction

endpackage

// File: rtl/lane_agg_slot_ctrl.sv
module lane_agg_slot_ctrl
    import lane_agg_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = SLOTS_PER_FRAME,
    localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  agg_mode_e         mode_req_i,
    output logic [SLOT_W-1:0] slot_o,
    output agg_mode_e         mode_o,
    output logic              blank_o
);

    logic [SLOT_W-1:0] slot_q;
    agg_mode_e         mode_q;
    logic              blank_q;
    logic              last_slot;

    assign last_slot = (slot_q == SLOT_W'(NUM_SLOTS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q  <= '0;
            mode_q  <= AGG_INTERLEAVE;
            blank_q <= 1'b1;
        end else begin
            slot_q <= last_slot ? '0 : slot_q + 1'b1;
            if (last_slot) begin
                mode_q  <= mode_req_i;
                blank_q <= 1'b0;
            end
        end
    end

    assign slot_o  = slot_q;
    assign mode_o  = mode_q;
    assign blank_o = blank_q;

    // R10: the mode may only move on the frame's last slot
    p_mode_boundary_r10: assert property (@(posedge clk) disable iff (rst)
        (slot_q != SLOT_W'(NUM_SLOTS - 1)) |=> $stable(mode_q));

    // R1: the blanking frame never reappears once it has ended
    p_blank_once_r1: assert property (@(posedge clk) disable iff (rst)
        !blank_q |=> !blank_q);

endmodule

// File: rtl/lane_agg_hold.sv
module lane_agg_hold
    import lane_agg_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [LANE_BYTE_W-1:0] data_i,
    input  logic                   valid_i,
    input  logic                   present_i,
    input  logic                   capture_en_i,
    input  logic                   slot_hit_i,
    input  logic                   flush_i,
    output lane_hold_t             hold_o
);

    lane_hold_t hold_q;
    logic       take;

    assign take = valid_i && present_i && capture_en_i;

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            hold_q.full <= 1'b0;
            hold_q.data <= '0;
        end else if (take) begin
            hold_q.full <= 1'b1;
            hold_q.data <= data_i;
        end else if (slot_hit_i) begin
            hold_q.full <= 1'b0;
        end
    end

    assign hold_o = hold_q;

    // R4: an absent lane never fills an empty register
    p_absent_no_fill_r4: assert property (@(posedge clk) disable iff (rst)
        (!present_i && !hold_q.full) |=> !hold_q.full);

    // R5: the register is empty after its slot unless a new byte arrived
    p_sent_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (slot_hit_i && !valid_i) |=> !hold_q.full);

endmodule

// File: rtl/lane_agg_out_mux.sv
module lane_agg_out_mux
    import lane_agg_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = SLOTS_PER_FRAME,
    localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  lane_hold_t [NUM_SLOTS-1:0]    holds_i,
    input  logic [NUM_SLOTS-1:0]          present_i,
    input  logic [LANE_BYTE_W-1:0]        pass_data_i,
    input  logic                          pass_take_i,
    input  logic [SLOT_W-1:0]             slot_i,
    input  agg_mode_e                     mode_i,
    input  logic                          blank_i,
    input  logic                          filler_we_i,
    input  logic [LANE_BYTE_W-1:0]        filler_wdata_i,
    output logic [LANE_BYTE_W-1:0]        byte_o,
    output logic                          frame_start_o
);

    logic [LANE_BYTE_W-1:0] filler_q;
    logic [LANE_BYTE_W-1:0] byte_q;
    logic                   fs_q;
    logic [LANE_BYTE_W-1:0] next_byte;
    logic                   next_fs;
    lane_hold_t             cur_hold;

    assign cur_hold = holds_i[slot_i];

    always_comb begin
        next_fs   = 1'b0;
        next_byte = filler_q;
        if (mode_i == AGG_PASS) begin
            if (pass_take_i) next_byte = pass_data_i;
        end else begin
            next_fs = (slot_i == '0);
            if (!blank_i && hold_ready(cur_hold, present_i[slot_i])) begin
                next_byte = cur_hold.data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            filler_q <= '0;
            byte_q   <= '0;
            fs_q     <= 1'b0;
        end else begin
            byte_q <= next_byte;
            fs_q   <= next_fs;
            if (filler_we_i) filler_q <= filler_wdata_i;
        end
    end

    assign byte_o        = byte_q;
    assign frame_start_o = fs_q;

    // R2: the marker only ever follows slot 0
    p_marker_slot0_r2: assert property (@(posedge clk) disable iff (rst)
        fs_q |-> ($past(slot_i) == '0));

    // R9: pass-through produces no marker
    p_pass_no_marker_r9: assert property (@(posedge clk) disable iff (rst)
        (mode_i == AGG_PASS) |=> !fs_q);

    // R1: the blanking frame sends only filler
    p_blank_filler_r1: assert property (@(posedge clk) disable iff (rst)
        blank_i |=> (byte_q == $past(filler_q)));

    // R4: an absent lane's slot carries filler
    p_absent_slot_filler_r4: assert property (@(posedge clk) disable iff (rst)
        ((mode_i == AGG_INTERLEAVE) && !present_i[slot_i]) |=> (byte_q == $past(filler_q)));

endmodule

// File: rtl/byte_lane_aggregator.sv
module byte_lane_aggregator
    import lane_agg_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = SLOTS_PER_FRAME,
    localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS),
    localparam int unsigned BUS_W    = NUM_SLOTS * LANE_BYTE_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [BUS_W-1:0]       lane_data_i,
    input  logic [NUM_SLOTS-1:0]   lane_valid_i,
    input  logic [NUM_SLOTS-1:0]   lane_present_i,
    input  logic                   mode_sel_i,
    input  logic                   filler_we_i,
    input  logic [LANE_BYTE_W-1:0] filler_wdata_i,
    output logic [LANE_BYTE_W-1:0] agg_byte_o,
    output logic                   frame_start_o
);

    logic [SLOT_W-1:0]          slot;
    agg_mode_e                  mode;
    logic                       blank;
    logic                       capture_en;
    logic                       flush;
    lane_hold_t [NUM_SLOTS-1:0] holds;

    lane_agg_slot_ctrl #(.NUM_SLOTS(NUM_SLOTS)) slot_ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .mode_req_i (agg_mode_e'(mode_sel_i)),
        .slot_o     (slot),
        .mode_o     (mode),
        .blank_o    (blank)
    );

    assign capture_en = (mode == AGG_INTERLEAVE) && !blank;
    assign flush      = (mode == AGG_PASS);

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_lane
        lane_agg_hold hold_i (
            .clk          (clk),
            .rst          (rst),
            .data_i       (lane_data_i[k*LANE_BYTE_W +: LANE_BYTE_W]),
            .valid_i      (lane_valid_i[k]),
            .present_i    (lane_present_i[k]),
            .capture_en_i (capture_en),
            .slot_hit_i   (slot == SLOT_W'(k)),
            .flush_i      (flush),
            .hold_o       (holds[k])
        );
    end

    lane_agg_out_mux #(.NUM_SLOTS(NUM_SLOTS)) out_mux_i (
        .clk            (clk),
        .rst            (rst),
        .holds_i        (holds),
        .present_i      (lane_present_i),
        .pass_data_i    (lane_data_i[LANE_BYTE_W-1:0]),
        .pass_take_i    (lane_valid_i[0] && lane_present_i[0]),
        .slot_i         (slot),
        .mode_i         (mode),
        .blank_i        (blank),
        .filler_we_i    (filler_we_i),
        .filler_wdata_i (filler_wdata_i),
        .byte_o         (agg_byte_o),
        .frame_start_o  (frame_start_o)
    );

endmodule

// File: tb/byte_lane_aggregator_tb_top.sv
module byte_lane_aggregator_tb_top;

    localparam int N = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic           rst;
    logic [N*8-1:0] lane_data;
    logic [N-1:0]   lane_valid;
    logic [N-1:0]   lane_present;
    logic           mode_sel;
    logic           filler_we;
    logic [7:0]     filler_wdata;
    logic [7:0]     agg_byte;
    logic           frame_start;

    byte_lane_aggregator dut_i (
        .clk            (clk),
        .rst            (rst),
        .lane_data_i    (lane_data),
        .lane_valid_i   (lane_valid),
        .lane_present_i (lane_present),
        .mode_sel_i     (mode_sel),
        .filler_we_i    (filler_we),
        .filler_wdata_i (filler_wdata),
        .agg_byte_o     (agg_byte),
        .frame_start_o  (frame_start)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // expectation state derived from the requirements
    int         m_slot;
    bit         m_pass;
    bit         m_blank;
    logic [7:0] m_filler;
    bit         m_full [N];
    logic [7:0] m_data [N];
    logic [31:0] rng = 32'h1234_5678;
    int          frame_no;

    function automatic logic [31:0] rnd();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng;
    endfunction

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s byte: actual %02h expected %02h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic check1(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s marker: actual %0b expected %0b (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic step(input string tag);
        logic [7:0] e_byte;
        logic       e_fs;
        bit         nf [N];
        logic [7:0] nd [N];
        int         s;
        bit         we;
        logic [7:0] wd;
        bit         msel;
        s    = m_slot;
        we   = filler_we;
        wd   = filler_wdata;
        msel = mode_sel;
        e_fs = !m_pass && (s == 0);
        if (m_pass)
            e_byte = (lane_valid[0] && lane_present[0]) ? lane_data[7:0] : m_filler;
        else if (m_blank)
            e_byte = m_filler;
        else
            e_byte = (m_full[s] && lane_present[s]) ? m_data[s] : m_filler;
        for (int k = 0; k < N; k++) begin
            nf[k] = m_full[k];
            nd[k] = m_data[k];
            if (m_pass) nf[k] = 0;
            else if (lane_valid[k] && lane_present[k] && !m_blank) begin
                nf[k] = 1;
                nd[k] = lane_data[k*8 +: 8];
            end else if (s == k) nf[k] = 0;
        end
        @(posedge clk);
        #1;
        check8(tag, agg_byte, e_byte);
        check1(tag, frame_start, e_fs);
        for (int k = 0; k < N; k++) begin
            m_full[k] = nf[k];
            m_data[k] = nd[k];
        end
        if (we) m_filler = wd;
        if (s == N - 1) begin
            m_pass  = msel;
            m_blank = 0;
        end
        m_slot = (s + 1) % N;
        if (m_slot == 0) frame_no++;
    endtask

    // one cycle of stimulus for a pattern, then an expectation step
    task automatic run_cycles(input string tag, input int pat, input int n);
        for (int c = 0; c < n; c++) begin
            logic [31:0] r;
            r = rnd();
            lane_data = {rnd(), rnd()};
            filler_we = 0;
            case (pat)
                0: begin lane_present = '1; lane_valid = '1; end
                1: begin
                    lane_present = '1;
                    for (int k = 0; k < N; k++) lane_valid[k] = (m_slot == (k + 3) % N);
                end
                2: begin lane_present = 8'b1010_0101; lane_valid = '1; end
                3: begin
                    if (r[3:0] == 4'd0) lane_present = r[15:8];
                    for (int k = 0; k < N; k++) lane_valid[k] = (m_slot == (k + 1) % N);
                end
                4: begin
                    lane_present = '1;
                    for (int k = 0; k < N; k++)
                        lane_valid[k] = (m_slot == (k + 5) % N) && ((frame_no % ((k % 4) + 1)) == 0);
                end
                5: begin
                    lane_present = '1;
                    for (int k = 0; k < N; k++) lane_valid[k] = (m_slot == (k + 2) % N) && r[k];
                end
                6: begin
                    lane_present = 8'b0110_1101;
                    lane_valid   = r[23:16];
                    filler_we    = r[31:29] == 3'd0;
                    filler_wdata = r[7:0];
                end
                7: begin lane_present = '1; lane_valid = '1; end
                8: begin
                    lane_present = '1;
                    for (int k = 0; k < N; k++) lane_valid[k] = (m_slot == k);
                end
                default: begin
                    lane_present = {7'h7f, r[2] | r[3]};
                    lane_valid   = {7'h00, r[0]};
                end
            endcase
            step(tag);
        end
    endtask

    initial begin
        rst = 1; lane_data = '0; lane_valid = '0; lane_present = '0;
        mode_sel = 0; filler_we = 0; filler_wdata = '0;
        repeat (3) @(posedge clk);
        #1;
        check8("R1", agg_byte, 8'h00);
        check1("R1", frame_start, 1'b0);
        m_slot = 0; m_pass = 0; m_blank = 1; m_filler = 8'h00; frame_no = 0;
        for (int k = 0; k < N; k++) begin m_full[k] = 0; m_data[k] = '0; end
        rst = 0;
        run_cycles("R1", 0, 8);
        run_cycles("R3", 1, 16 * N);
        run_cycles("R2", 0, 4 * N);
        run_cycles("R4", 2, 8 * N);
        run_cycles("R6", 3, 16 * N);
        run_cycles("R7", 4, 24 * N);
        run_cycles("R5", 5, 12 * N);
        run_cycles("R8", 6, 10 * N);
        run_cycles("R11", 7, 6 * N);
        run_cycles("R12", 8, 6 * N);
        // move to pass-through with the request raised mid-frame
        while (m_slot != 3) run_cycles("R10", 1, 1);
        mode_sel = 1;
        run_cycles("R10", 1, 2 * N);
        run_cycles("R9", 9, 6 * N);
        while (m_slot != 6) run_cycles("R9", 9, 1);
        mode_sel = 0;
        run_cycles("R10", 9, 2 * N);
        run_cycles("R3", 1, 4 * N);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog R1: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule